// File: doc/BRIEF.md
# Long-Duration Countdown Alarm Timer

The block counts down a wake-up interval of up to sixteen weeks minus one second. The count is kept in five mixed-radix fields: seconds, minutes, hours, days and weeks. Each accepted pulse on a one-second tick input takes one second off the count, borrowing between fields as needed. When a tick arrives while every field is already zero, the block sets a sticky expiry flag and stops counting. The flag can raise an interrupt, a standby wake request, or both.

Software uses a small byte-wide register port. It loads the five fields, turns the timer clock on, picks the power source and sets the interrupt and wake enables. It then requests a start and polls until the synchronised run state reads back as set. Several rules protect a running timer:

- The count fields, the power-source select and the clock-on bit cannot be changed while the timer runs.
- A start request is refused until the clock has been on for a programmable settling interval.
- The wake request can only reach the output when the standby supply is selected.

Top module: `cdt_alarm_top`

## Requirements
- R1: After reset every register reads 0 (control at address 0, status at address 1, count fields at addresses 2 to 6), and irq_o and wake_o are low.
- R2: The count fields are seconds at address 2 (0–59), minutes at address 3 (0–59), hours at address 4 (0–23), days at address 5 (0–6) and weeks at address 6 (0–15). A written value above a field's maximum is stored as that maximum.
- R3: Each accepted tick takes one second off the count. A field that is zero reloads to its maximum and borrows one from the next larger field.
- R4: A tick that arrives while all fields are zero sets status bit 0 and leaves the count at zero. No later tick changes the count or sets the status again until the fields are written or the timer is restarted. A zero count therefore expires on the first tick, so the shortest interval is one second.
- R5: Writing 1 to status bit 0 clears it. Any accepted write to a count field also clears it.
- R6: While a start is requested, or the run state is still active, the block ignores writes to the count fields and to control bits 1 (clock on) and 2 (standby source).
- R7: A write of control bit 0 (start) = 1 is ignored unless control bit 1 has been set for at least SETTLE_CYCLES consecutive clock cycles.
- R8: Control bit 0 reads back the synchronised run state. After an accepted start or stop write it changes SYNC_STAGES clock cycles later.
- R9: irq_o is high exactly when status bit 0 and control bit 3 (interrupt enable) are both set.
- R10: wake_o is high only when status bit 0, control bit 4 (wake enable) and control bit 2 (standby source) are all set.
- R11: Ticks have no effect while the timer is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one clock cycle wide per second |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from reg_addr_i) |
| irq_o | output | 1 | Expiry interrupt |
| wake_o | output | 1 | Standby wake request |

## Verification
The hardest situations to reach from the ports are a borrow rippling across several zero fields at once and an expiry after a long stretch of counting. Reaching them with one-second ticks would take weeks of simulated time. The bench instead holds tick_i high for many consecutive cycles. It also loads field patterns chosen at random, with the low fields often forced to zero, so that each short run crosses week, day and hour boundaries. A reference model in the bench converts the fields to a total count of seconds and predicts every field after the run.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DW          = 8;
  localparam int AW          = 3;
  localparam int NUM_FIELDS  = 5;
  localparam int FIELD_BASE  = 2;

  localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADDR_STAT = 3'd1;

  // control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_CLK  = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_IRQ  = 3;
  localparam int CB_WAKE = 4;

  function automatic int field_max(input int idx);
    case (idx)
      0:       return 59;
      1:       return 59;
      2:       return 23;
      3:       return 6;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/cdt_field.sv
module cdt_field #(
  parameter int MAX = 59,
  localparam int W  = $clog2(MAX + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [cdt_pkg::DW-1:0] load_val_i,
  input  logic                  dec_i,
  output logic [W-1:0]          val_o,
  output logic                  zero_o
);
  localparam logic [cdt_pkg::DW-1:0] MAX_B = cdt_pkg::DW'(MAX);
  localparam logic [W-1:0]           MAX_W = W'(MAX);

  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (load_i) begin
      val_q <= (load_val_i > MAX_B) ? MAX_W : load_val_i[W-1:0];
    end else if (dec_i) begin
      val_q <= (val_q == '0) ? MAX_W : val_q - 1'b1;
    end
  end

  assign val_o  = val_q;
  assign zero_o = (val_q == '0);

  a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q <= MAX_W);
  a_r3_borrow_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && val_q == '0) |=> val_q == MAX_W);
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl #(
  parameter int SETTLE_CYCLES = 150,
  parameter int SYNC_STAGES   = 2,
  localparam int SCW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [cdt_pkg::AW-1:0]         addr_i,
  input  logic [cdt_pkg::DW-1:0]         wdata_i,
  input  logic                           expire_i,
  output logic                           en_sync_o,
  output logic                           clk_on_o,
  output logic                           src_sb_o,
  output logic                           irq_en_o,
  output logic                           wake_en_o,
  output logic                           evt_o,
  output logic                           locked_o,
  output logic [cdt_pkg::NUM_FIELDS-1:0] field_load_o
);
  import cdt_pkg::*;

  logic                   en_req_q, clk_on_q, src_q, irq_en_q, wake_en_q, evt_q;
  logic [SCW-1:0]         settle_q;
  logic                   settle_done;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ctrl_we, stat_we, locked;

  assign locked  = en_req_q | sync_q[SYNC_STAGES-1];
  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);
  assign stat_we = we_i && (addr_i == ADDR_STAT);
  assign settle_done = (settle_q == SCW'(SETTLE_CYCLES));

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_load
    localparam logic [AW-1:0] FADDR = AW'(FIELD_BASE + k);
    assign field_load_o[k] = we_i && !locked && (addr_i == FADDR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_req_q  <= 1'b0;
      clk_on_q  <= 1'b0;
      src_q     <= 1'b0;
      irq_en_q  <= 1'b0;
      wake_en_q <= 1'b0;
    end else if (ctrl_we) begin
      en_req_q  <= wdata_i[CB_RUN] & settle_done;
      irq_en_q  <= wdata_i[CB_IRQ];
      wake_en_q <= wdata_i[CB_WAKE];
      if (!locked) begin
        clk_on_q <= wdata_i[CB_CLK];
        src_q    <= wdata_i[CB_SRC];
      end
    end
  end

  // settling counter, saturating, restarts when clock is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          settle_q <= '0;
    else if (!clk_on_q)   settle_q <= '0;
    else if (!settle_done) settle_q <= settle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], en_req_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  evt_q <= 1'b0;
    else if (expire_i)                            evt_q <= 1'b1;
    else if ((stat_we && wdata_i[0]) || (|field_load_o)) evt_q <= 1'b0;
  end

  assign en_sync_o = sync_q[SYNC_STAGES-1];
  assign clk_on_o  = clk_on_q;
  assign src_sb_o  = src_q;
  assign irq_en_o  = irq_en_q;
  assign wake_en_o = wake_en_q;
  assign evt_o     = evt_q;
  assign locked_o  = locked;

  a_r7_settled_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_req_q) |-> $past(settle_done));
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && wdata_i[0] && !expire_i) |=> !evt_q);
  a_r6_clk_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && locked) |=> ($stable(clk_on_q) && $stable(src_q)));
endmodule

// File: rtl/cdt_alarm_top.sv
module cdt_alarm_top #(
  parameter int SETTLE_CYCLES = 150,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  output logic       wake_o
);
  import cdt_pkg::*;

  logic en_sync, clk_on, src_sb, irq_en, wake_en, evt, locked;
  logic [NUM_FIELDS-1:0] field_load, field_zero, field_dec;
  logic [DW-1:0]         field_val [NUM_FIELDS];
  logic all_zero, active, tick_ok, step, expire;
  logic expired_q, en_sync_d;

  cdt_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .expire_i(expire),
    .en_sync_o(en_sync), .clk_on_o(clk_on), .src_sb_o(src_sb),
    .irq_en_o(irq_en), .wake_en_o(wake_en), .evt_o(evt),
    .locked_o(locked), .field_load_o(field_load)
  );

  assign all_zero = &field_zero;
  assign active   = en_sync & clk_on & ~expired_q;
  assign tick_ok  = active & tick_i;
  assign step     = tick_ok & ~all_zero;
  assign expire   = tick_ok & all_zero;

  // borrow chain: a field decrements when all smaller fields are zero
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    localparam int FMAX = field_max(k);
    localparam int FW   = $clog2(FMAX + 1);
    logic [FW-1:0] v;
    if (k == 0) begin : g_first
      assign field_dec[k] = step;
    end else begin : g_rest
      assign field_dec[k] = field_dec[k-1] & field_zero[k-1];
    end
    cdt_field #(.MAX(FMAX)) u_field (
      .clk_i, .rst_ni,
      .load_i(field_load[k]), .load_val_i(reg_wdata_i),
      .dec_i(field_dec[k]), .val_o(v), .zero_o(field_zero[k])
    );
    assign field_val[k] = DW'(v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      expired_q <= 1'b0;
      en_sync_d <= 1'b0;
    end else begin
      en_sync_d <= en_sync;
      if (expire)                                     expired_q <= 1'b1;
      else if ((|field_load) || (en_sync && !en_sync_d)) expired_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CB_RUN]  = en_sync;
        reg_rdata_o[CB_CLK]  = clk_on;
        reg_rdata_o[CB_SRC]  = src_sb;
        reg_rdata_o[CB_IRQ]  = irq_en;
        reg_rdata_o[CB_WAKE] = wake_en;
      end
      ADDR_STAT: reg_rdata_o[0] = evt;
      3'd2:      reg_rdata_o = field_val[0];
      3'd3:      reg_rdata_o = field_val[1];
      3'd4:      reg_rdata_o = field_val[2];
      3'd5:      reg_rdata_o = field_val[3];
      3'd6:      reg_rdata_o = field_val[4];
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o  = evt & irq_en;
  assign wake_o = evt & wake_en & src_sb;

  logic [NUM_FIELDS*DW-1:0] count_vec;
  assign count_vec = {field_val[4], field_val[3], field_val[2], field_val[1], field_val[0]};

  a_r4_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_q && !(|field_load)) |=> ($stable(count_vec) && count_vec == '0));
  a_r6_fields_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && locked && !tick_i) |=> $stable(count_vec));
  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_sync && !(|field_load)) |=> $stable(count_vec));
  a_r10_wake_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (src_sb && evt));
endmodule

// File: tb/cdt_alarm_top_bench.sv
module cdt_alarm_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 150;
  localparam int SYNC       = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_alarm_top #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(SYNC)) u_cdt_alarm_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  function automatic logic [7:0] ctrl_byte(bit run, bit clkon, bit src, bit ie, bit we_n);
    return {3'b000, we_n, ie, src, clkon, run};
  endfunction

  function automatic int to_secs(int s, int m, int h, int d, int w);
    return s + 60*m + 3600*h + 86400*d + 604800*w;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int s, int m, int h, int d, int w);
    wr(3'd2, 8'(s)); wr(3'd3, 8'(m)); wr(3'd4, 8'(h)); wr(3'd5, 8'(d)); wr(3'd6, 8'(w));
  endtask

  task automatic check_fields(string req, int secs);
    int v;
    int r;
    r = secs;
    rd(3'd6, v); check(req, v, r / 604800); r = r % 604800;
    rd(3'd5, v); check(req, v, r / 86400);  r = r % 86400;
    rd(3'd4, v); check(req, v, r / 3600);   r = r % 3600;
    rd(3'd3, v); check(req, v, r / 60);
    rd(3'd2, v); check(req, v, r % 60);
  endtask

  // stop, load, start with the given control bits, tick n, compare with model
  task automatic run_case(string req, int s, int m, int h, int d, int w, int n,
                          bit src, bit ie, bit wen);
    int total, rem, v;
    bit exp_evt;
    wr(3'd0, ctrl_byte(1'b0, 1'b1, src, ie, wen));
    idle(SYNC + 1);
    load(s, m, h, d, w);
    wr(3'd0, ctrl_byte(1'b1, 1'b1, src, ie, wen));
    idle(SYNC + 1);
    ticks(n);
    total   = to_secs(s, m, h, d, w);
    exp_evt = (n > total);
    rem     = exp_evt ? 0 : total - n;
    check_fields(req, rem);
    rd(3'd1, v); check({req, " status"}, v, int'(exp_evt));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int v;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); check("R1 reset reg", v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 wake", int'(wake), 0);

    // R2 saturation on write
    load(255, 60, 24, 7, 200);
    rd(3'd2, v); check("R2 sec max", v, 59);
    rd(3'd3, v); check("R2 min max", v, 59);
    rd(3'd4, v); check("R2 hour max", v, 23);
    rd(3'd5, v); check("R2 day max", v, 6);
    rd(3'd6, v); check("R2 week max", v, 15);

    // R11 ticks while idle
    ticks(5);
    check_fields("R11 idle ticks", to_secs(59, 59, 23, 6, 15));

    // R7 start refused before settling
    wr(3'd0, ctrl_byte(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    wr(3'd0, ctrl_byte(1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
    idle(SYNC + 2);
    rd(3'd0, v); check("R7 early start ignored", v & 1, 0);
    idle(SETTLE + 5);

    // R8 run readback delay
    wr(3'd0, ctrl_byte(1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
    rd(3'd0, v); check("R8 not yet synced", v & 1, 0);
    idle(SYNC);
    rd(3'd0, v); check("R8 synced", v & 1, 1);

    // R6 locked writes
    wr(3'd2, 8'd5);
    rd(3'd2, v); check("R6 field locked", v, 59);
    wr(3'd0, ctrl_byte(1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    rd(3'd0, v); check("R6 clk/src locked", v & 6, 2);

    // R3 full-range borrow from the max count
    ticks(1);
    check_fields("R3 max minus one", to_secs(59, 59, 23, 6, 15) - 1);

    // R3 directed borrows
    run_case("R3 minute borrow", 0, 1, 0, 0, 0, 1, 1'b0, 1'b1, 1'b1);
    run_case("R3 week borrow", 0, 0, 0, 0, 1, 1, 1'b0, 1'b1, 1'b1);
    run_case("R3 exact expiry edge", 3, 0, 0, 0, 0, 3, 1'b0, 1'b1, 1'b1);

    // R4 zero count expires on first tick; R9 irq; R10 wake blocked w/o standby
    run_case("R4 zero expires", 0, 0, 0, 0, 0, 1, 1'b0, 1'b1, 1'b1);
    check("R9 irq on expiry", int'(irq), 1);
    check("R10 wake needs standby", int'(wake), 0);
    ticks(4);
    check_fields("R4 stays zero", 0);
    rd(3'd1, v); check("R4 status held", v, 1);

    // R5 write-one-to-clear
    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R5 w1c", v, 0);
    check("R9 irq cleared", int'(irq), 0);
    ticks(3);
    rd(3'd1, v); check("R4 no refire", v, 0);

    // R10 wake with standby source; R9 irq masked
    run_case("R10 standby expiry", 0, 0, 0, 0, 0, 2, 1'b1, 1'b0, 1'b1);
    check("R10 wake", int'(wake), 1);
    check("R9 irq masked", int'(irq), 0);

    // R5 field write clears status
    wr(3'd0, ctrl_byte(1'b0, 1'b1, 1'b1, 1'b0, 1'b1));
    idle(SYNC + 1);
    wr(3'd3, 8'd2);
    rd(3'd1, v); check("R5 load clears", v, 0);
    check("R10 wake off", int'(wake), 0);

    // R3 random patterns
    for (int i = 0; i < 24; i++) begin
      int s, m, h, d, w, n;
      s = $urandom_range(0, 59); m = $urandom_range(0, 59);
      h = $urandom_range(0, 23); d = $urandom_range(0, 6);
      w = $urandom_range(0, 15);
      if ($urandom_range(0, 1) == 1) begin s = $urandom_range(0, 2); m = 0; end
      if ($urandom_range(0, 3) == 0) begin h = 0; d = 0; end
      if ($urandom_range(0, 5) == 0) begin w = 0; d = 0; h = 0; m = $urandom_range(0, 1); end
      n = $urandom_range(0, 150);
      run_case("R3 random", s, m, h, d, w, n, 1'($urandom_range(0, 1)), 1'b1, 1'b0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule